// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit resolves one conditional branch per strobe. It receives a fetched 32-bit branch word, the address of that branch, the address of the following instruction, a processor status word that holds the four integer flags, a floating-point status word that holds a two-bit compare result, and a flag that says whether a floating-point unit is present. From the branch word it picks one of two sixteen-entry condition tables, integer or floating-point. It then decides whether the branch is taken and works out where fetch continues after the delay slot. It also reports whether the delay-slot instruction must be squashed.

Each decision is registered on `valid_in` and comes out one cycle later, together with `valid_out`. The outputs keep their value until the next strobe. A floating-point branch issued while the floating-point unit is disabled or absent does not branch. It raises `fp_trap` instead, and the pipeline uses that flag to redirect to its trap handler.

Top module: `brdec_unit`

## Requirements
- R1: While `rst_n` is low and after its release, until the first strobe, `valid_out`, `taken`, `annul` and `fp_trap` are 0 and `next_npc` is 0.
- R2: `valid_out` is high exactly in the cycle after a cycle with `valid_in` high. Without a strobe, `taken`, `annul`, `fp_trap` and `next_npc` hold their values.
- R3: The condition code is `insn[28:25]` and the annul bit is `insn[29]`. When `insn[24:22]` equals 3'b110 the floating-point table is used. Every other value selects the integer table.
- R4: The integer flags are `proc_status[23:20]`, with N at bit 23, Z at 22, V at 21 and C at 20. Codes 0 to 7 are true on: never, Z, Z|(N^V), N^V, C|Z, C, N and V. Each code 8+k is the inverse of code k. So 8 is always, 10 is greater !(Z|(N^V)), 11 is greater-or-equal !(N^V), 12 is greater-unsigned !(C|Z), and 13, 14 and 15 are carry-clear, positive and overflow-clear.
- R5: The floating-point compare code is `fp_status[11:10]`: 0 means equal, 1 less, 2 greater, 3 unordered. Codes 0 to 7 are true on: never, not-equal, less-or-greater, unordered-or-less, less, unordered-or-greater, greater and unordered. Each code 8+k is the inverse of code k. So 8 is always, 10 is unordered-or-equal (true unless less or greater), and 15 is ordered.
- R6: A taken branch sets `next_npc` to `pc` plus the sign-extended 22-bit displacement `insn[21:0]` shifted left by two. The sum wraps modulo 2^32.
- R7: A branch that is not taken, or that traps, sets `next_npc` to `npc + 4`.
- R8: When the branch is taken, `annul` is 1 only if the code is 8 (always) and the annul bit is set.
- R9: When the branch is not taken and does not trap, `annul` equals the annul bit.
- R10: A floating-point-table branch with `proc_status[12]` (floating-point enable) clear or `fpu_present` low gives `fp_trap` = 1, `taken` = 0 and `annul` = 0. Integer-table branches never set `fp_trap`.
- R11: `taken` is 1 when the selected condition holds and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Strobe: resolve the branch on the inputs this cycle |
| insn | input | 32 | Fetched branch instruction word |
| pc | input | 32 | Address of the branch |
| npc | input | 32 | Address of the delay-slot instruction |
| proc_status | input | 32 | Processor status; flags at 23:20, floating-point enable at 12 |
| fp_status | input | 32 | Floating-point status; compare code at 11:10 |
| fpu_present | input | 1 | High when a floating-point unit is fitted |
| valid_out | output | 1 | Decision valid, one cycle after `valid_in` |
| taken | output | 1 | Branch taken |
| annul | output | 1 | Squash the delay-slot instruction |
| fp_trap | output | 1 | Disabled floating-point unit trap request |
| next_npc | output | 32 | Fetch address after the delay slot |

## Verification
Every integer code is applied under all sixteen N/Z/V/C combinations, with the annul bit both clear and set. This separates each table entry from its inverse and from its neighbours, and it exercises both annul rules. Every floating-point code is applied under all four compare results, with the unit enabled. A second pass applies the same codes with the enable bit clear or the unit absent, which tells the trap path apart from a plain not-taken branch. Displacement corners (largest forward, largest backward, zero, and a sum that wraps past 2^32) check the target adder. Idle cycles with changed inputs show that the registered outputs hold.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } icc_t;

  typedef enum logic [1:0] {
    FCMP_EQ = 2'd0,
    FCMP_LT = 2'd1,
    FCMP_GT = 2'd2,
    FCMP_UN = 2'd3
  } fcmp_e;

  localparam logic [3:0] COND_ALWAYS = 4'd8;
  localparam logic [2:0] FMT_FP_BRANCH = 3'b110;

  // Lower half of the integer table; the upper half is its inverse.
  function automatic logic icc_base(input logic [2:0] sel, input icc_t f);
    logic r;
    case (sel)
      3'd0: r = 1'b0;
      3'd1: r = f.z;
      3'd2: r = f.z | (f.n ^ f.v);
      3'd3: r = f.n ^ f.v;
      3'd4: r = f.c | f.z;
      3'd5: r = f.c;
      3'd6: r = f.n;
      default: r = f.v;
    endcase
    return r;
  endfunction

  // Lower half of the floating-point table; the upper half is its inverse.
  function automatic logic fcc_base(input logic [2:0] sel, input fcmp_e c);
    logic r;
    case (sel)
      3'd0: r = 1'b0;
      3'd1: r = (c != FCMP_EQ);
      3'd2: r = (c == FCMP_LT) | (c == FCMP_GT);
      3'd3: r = (c == FCMP_UN) | (c == FCMP_LT);
      3'd4: r = (c == FCMP_LT);
      3'd5: r = (c == FCMP_UN) | (c == FCMP_GT);
      3'd6: r = (c == FCMP_GT);
      default: r = (c == FCMP_UN);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/brdec_cond_eval.sv
module brdec_cond_eval
  import brdec_pkg::*;
#(
  parameter bit FP_TABLE = 1'b0
) (
  input  logic [3:0] code,
  input  icc_t       flags,
  input  logic [1:0] fcc,
  output logic       hit
);
  logic base;

  generate
    if (FP_TABLE) begin : g_fp
      logic unused_ok;
      assign unused_ok = ^flags;
      assign base = fcc_base(code[2:0], fcmp_e'(fcc));
    end else begin : g_int
      logic unused_ok;
      assign unused_ok = ^fcc;
      assign base = icc_base(code[2:0], flags);
    end
  endgenerate

  // Bit 3 of the code selects the inverted half of the table.
  assign hit = base ^ code[3];
endmodule

// File: rtl/brdec_target.sv
module brdec_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 22
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] offset;
  assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign target = pc + offset;
endmodule

// File: rtl/brdec_unit.sv
module brdec_unit
  import brdec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 22,
  parameter int FLAG_LSB  = 20,
  parameter int FP_EN_BIT = 12,
  parameter int FCC_LSB   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [31:0]       insn,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] npc,
  input  logic [31:0]       proc_status,
  input  logic [31:0]       fp_status,
  input  logic              fpu_present,
  output logic              valid_out,
  output logic              taken,
  output logic              annul,
  output logic              fp_trap,
  output logic [ADDR_W-1:0] next_npc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  // Named decode events, visible to the bound checker.
  logic [3:0]        cond_code;
  logic              annul_bit;
  logic              use_fp;
  logic              fp_usable;
  logic              trap_now;
  logic              int_hit;
  logic              fp_hit;
  logic              take_now;
  logic              annul_now;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] fall_thru;
  logic [ADDR_W-1:0] npc_now;
  icc_t              flags;
  logic [1:0]        fcc;

  assign cond_code = insn[28:25];
  assign annul_bit = insn[29];
  assign use_fp    = (insn[24:22] == FMT_FP_BRANCH);
  assign flags     = icc_t'(proc_status[FLAG_LSB+3:FLAG_LSB]);
  assign fcc       = fp_status[FCC_LSB+1:FCC_LSB];
  assign fp_usable = proc_status[FP_EN_BIT] & fpu_present;
  assign trap_now  = use_fp & ~fp_usable;

  brdec_cond_eval #(.FP_TABLE(1'b0)) u_int_tbl (
    .code (cond_code),
    .flags(flags),
    .fcc  (fcc),
    .hit  (int_hit)
  );

  brdec_cond_eval #(.FP_TABLE(1'b1)) u_fp_tbl (
    .code (cond_code),
    .flags(flags),
    .fcc  (fcc),
    .hit  (fp_hit)
  );

  brdec_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc    (pc),
    .disp  (insn[DISP_W-1:0]),
    .target(target)
  );

  assign take_now  = (use_fp ? fp_hit : int_hit) & ~trap_now;
  assign fall_thru = npc + STEP;
  assign npc_now   = take_now ? target : fall_thru;

  always_comb begin
    if (trap_now)
      annul_now = 1'b0;
    else if (take_now)
      annul_now = annul_bit & (cond_code == COND_ALWAYS);
    else
      annul_now = annul_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      taken     <= 1'b0;
      annul     <= 1'b0;
      fp_trap   <= 1'b0;
      next_npc  <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        taken    <= take_now;
        annul    <= annul_now;
        fp_trap  <= trap_now;
        next_npc <= npc_now;
      end
    end
  end
endmodule

// File: rtl/brdec_unit_chk.sv
module brdec_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_in,
  input logic [31:0]       insn,
  input logic [ADDR_W-1:0] npc,
  input logic              use_fp,
  input logic              valid_out,
  input logic              taken,
  input logic              annul,
  input logic              fp_trap,
  input logic [ADDR_W-1:0] next_npc
);
  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);

  // R2
  hold_npc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(next_npc) && $stable(taken) && $stable(annul));

  // R7
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> (taken || next_npc == $past(npc) + ADDR_W'(4)));

  // R8
  annul_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> (!(taken && annul) || $past(insn[28:25]) == 4'd8));

  // R9
  annul_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !insn[29]) |=> !annul);

  // R10
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && fp_trap) |-> (!taken && !annul));

  // R10
  int_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !use_fp) |=> !fp_trap);
endmodule

bind brdec_unit brdec_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_in (valid_in),
  .insn     (insn),
  .npc      (npc),
  .use_fp   (use_fp),
  .valid_out(valid_out),
  .taken    (taken),
  .annul    (annul),
  .fp_trap  (fp_trap),
  .next_npc (next_npc)
);

// File: tb/brdec_unit_bench.sv
`timescale 1ns/1ps
module brdec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] insn = '0, pc = '0, npc = '0, proc_status = '0, fp_status = '0;
  logic        fpu_present = 1'b0;
  logic        valid_out, taken, annul, fp_trap;
  logic [31:0] next_npc;

  int applied = 0;
  int fails = 0;
  bit done = 0;
  logic exp_valid = 1'b0;

  always #2.5 clk = ~clk;

  brdec_unit u_brdec_unit (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .insn(insn), .pc(pc),
    .npc(npc), .proc_status(proc_status), .fp_status(fp_status),
    .fpu_present(fpu_present), .valid_out(valid_out), .taken(taken),
    .annul(annul), .fp_trap(fp_trap), .next_npc(next_npc)
  );

  // Behavioural model of the strobe delay (R2), compared every clock.
  always @(posedge clk) exp_valid <= rst_n ? valid_in : 1'b0;
  always @(negedge clk) if (!done) begin
    applied++;
    if (valid_out !== exp_valid) begin
      fails++;
      $display("FAIL R2 valid_out act=%0b exp=%0b", valid_out, exp_valid);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit int_cond(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], v = f[1], cy = f[0];
    case (c)
      0: return 0;            8: return 1;
      1: return z;            9: return !z;
      2: return z || (n != v); 10: return !(z || (n != v));
      3: return n != v;       11: return n == v;
      4: return cy || z;      12: return !(cy || z);
      5: return cy;           13: return !cy;
      6: return n;            14: return !n;
      default: return v == 1'b1 ? c == 7 : c == 15;
    endcase
  endfunction

  function automatic bit fp_cond(input logic [3:0] c, input logic [1:0] k);
    bit e = (k == 0), l = (k == 1), g = (k == 2), u = (k == 3);
    case (c)
      0: return 0;   8: return 1;
      1: return !e;  9: return e;
      2: return l || g; 10: return e || u;
      3: return u || l; 11: return e || g;
      4: return l;   12: return !l;
      5: return u || g; 13: return e || l;
      6: return g;   14: return !g;
      7: return u;   default: return !u;
    endcase
  endfunction

  // Apply one vector, then check the registered result at the next falling edge.
  task automatic apply(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] np, input logic [31:0] ps,
                       input logic [31:0] fs, input bit fpp, input string req);
    bit is_fp, trap, hit, tk, an;
    logic [31:0] nn;
    insn = i; pc = p; npc = np; proc_status = ps; fp_status = fs;
    fpu_present = fpp; valid_in = 1'b1;
    is_fp = (i[24:22] == 3'b110);
    trap  = is_fp && !(ps[12] && fpp);
    hit   = is_fp ? fp_cond(i[28:25], fs[11:10]) : int_cond(i[28:25], ps[23:20]);
    tk    = hit && !trap;
    if (trap) an = 0;
    else if (tk) an = i[29] && i[28:25] == 4'd8;
    else an = i[29];
    nn = tk ? p + ({{10{i[21]}}, i[21:0]} << 2) : np + 32'd4;
    @(negedge clk);
    check(taken === tk, {req, " R11 taken"}, {31'd0, taken}, {31'd0, tk});
    check(annul === an, {req, " R8/R9 annul"}, {31'd0, annul}, {31'd0, an});
    check(fp_trap === trap, {req, " R10 fp_trap"}, {31'd0, fp_trap}, {31'd0, trap});
    check(next_npc === nn, {req, " R6/R7 next_npc"}, next_npc, nn);
  endtask

  function automatic logic [31:0] mk(input bit a, input logic [3:0] c,
                                     input bit fp, input logic [21:0] d);
    return {2'b00, a, c, fp ? 3'b110 : 3'b010, d};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] h_npc;
    logic h_tk;
    repeat (3) @(negedge clk);
    // R1 during reset
    check({valid_out, taken, annul, fp_trap} === 4'b0, "R1 flags in reset",
          {28'd0, valid_out, taken, annul, fp_trap}, 32'd0);
    check(next_npc === 32'd0, "R1 next_npc in reset", next_npc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({taken, annul, fp_trap} === 3'b0 && next_npc === 0, "R1 after release",
          next_npc, 32'd0);

    // R4 integer table sweep (R3 selects integer format)
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        for (int a = 0; a < 2; a++)
          apply(mk(a[0], c[3:0], 0, 22'h00_0010 + 22'(f)), 32'h4000_0000 + 32'(c << 8),
                32'h4000_0004 + 32'(c << 8), {8'h00, f[3:0], 20'h01000}, 32'h0,
                1'b1, "R4");

    // R5 floating-point table sweep, unit enabled
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 2; a++)
          apply(mk(a[0], c[3:0], 1, 22'h3F_FFF0), 32'h0000_2000, 32'h0000_2004,
                {8'h00, 4'hF, 20'h01000}, {20'd0, k[1:0], 10'd0}, 1'b1, "R5");

    // R10 disabled: enable bit clear, then unit absent
    for (int c = 0; c < 16; c++) begin
      apply(mk(1, c[3:0], 1, 22'h12), 32'h100, 32'h104, 32'h0, 32'h0, 1'b1, "R10 en=0");
      apply(mk(1, c[3:0], 1, 22'h12), 32'h100, 32'h104, 32'h1000, 32'h0, 1'b0, "R10 absent");
      apply(mk(0, c[3:0], 0, 22'h12), 32'h100, 32'h104, 32'h0, 32'h0, 1'b0, "R10 int ok");
    end

    // R6 displacement corners
    apply(mk(0, 8, 0, 22'h1F_FFFF), 32'h1000_0000, 32'h1000_0004, 0, 0, 1, "R6 max fwd");
    apply(mk(0, 8, 0, 22'h20_0000), 32'h1000_0000, 32'h1000_0004, 0, 0, 1, "R6 max back");
    apply(mk(1, 8, 0, 22'h00_0000), 32'h0000_0040, 32'h0000_0044, 0, 0, 1, "R6 zero R8");
    apply(mk(0, 8, 0, 22'h00_0004), 32'hFFFF_FFF8, 32'hFFFF_FFFC, 0, 0, 1, "R6 wrap");
    apply(mk(0, 0, 0, 22'h00_0004), 32'h0, 32'hFFFF_FFFC, 0, 0, 1, "R7 wrap");

    // R2 hold: no strobe while inputs change
    h_npc = next_npc; h_tk = taken;
    valid_in = 1'b0;
    insn = mk(1, 8, 0, 22'h55); pc = 32'h9999_0000; npc = 32'h1234;
    @(negedge clk);
    @(negedge clk);
    check(next_npc === h_npc, "R2 hold next_npc", next_npc, h_npc);
    check(taken === h_tk && annul === 1'b0, "R2 hold flags", {31'd0, taken}, {31'd0, h_tk});

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule